// File: doc/BRIEF.md
# SDRAM Page-Policy Command Sequencer

This block converts single read and write requests from a system bus into SDRAM command sequences. It holds one request at a time, decides which of ACTIVE, PRECHARGE, READ and WRITE to issue, enforces the row-to-column delay and the precharge recovery delay, and waits the configured CAS latency before it returns read data. Refresh, mode-register programming and chip-select decoding are handled elsewhere.

A static configuration bit selects the page policy. In closed-page mode each access opens its row and finishes with an auto-precharging READ or WRITE, so no row stays open. In open-page mode the block keeps a row register and a valid flag for each of four banks. A hit on the open row goes straight to READ or WRITE. A miss on an idle bank opens the row first. A conflict closes the old row, then opens the new one. A precharge-all request closes every bank and clears the table. Further configuration inputs set the CAS latency, the idle data-bus behaviour and whether the devices have two or four banks.

The request address is laid out as {bank[1:0], row, column}. The bus master holds `req_valid_i` and its fields steady until it sees a one-cycle `req_ack_o`.

Top module: `sdram_page_seq`

## Requirements
- R1: With `cfg_close_page_i`=1, every access first issues ACTIVE. The READ/WRITE that follows has address bit 10 set (auto-precharge), so a repeat access to the same row issues ACTIVE again. If the bank still holds a row from open-page mode, a PRECHARGE comes before the ACTIVE. Command encoding {ras_n,cas_n,we_n}: NOP=111, ACTIVE=011, READ=101, WRITE=100, PRECHARGE=010.
- R2: With `cfg_close_page_i`=0, an access to a bank with no open row issues ACTIVE with no PRECHARGE, then a READ/WRITE with address bit 10 clear. The row then stays open.
- R3: In open-page mode, an access to the open row of its bank issues READ/WRITE as its first command, in the cycle after the request is accepted.
- R4: In open-page mode, an access to a different row of an open bank issues PRECHARGE to that bank (address bit 10 clear), then ACTIVE, then READ/WRITE.
- R5: Each of the four banks keeps its own open row, so rows opened in all four banks are all hits afterwards.
- R6: READ/WRITE follows ACTIVE by exactly TRCD cycles on a miss. ACTIVE follows PRECHARGE by exactly TRP cycles on a conflict. ACTIVE is never issued less than TRP cycles after any precharge, auto-precharge or precharge-all.
- R7: Read data is sampled from `sd_dq_i` CL cycles after the READ command and is returned on `req_rdata_o` with `req_ack_o`. `cfg_cas_i` 01 gives CL1, 10 gives CL2, 11 gives CL3, and the reserved 00 gives CL3.
- R8: With `cfg_bus_release_i`=0, `sd_dq_oe_o` is high except while a read is in flight, and `sd_dq_o` holds the last write data. With `cfg_bus_release_i`=1, `sd_dq_oe_o` is high only in the WRITE cycle.
- R9: With `cfg_four_bank_i`=0, the bank is {0, address bit 21}: `sd_ba_o[1]` is 0 on every command, and addresses that differ only in bit 22 map to the same bank.
- R10: A request with `req_pall_i`=1 issues PRECHARGE with address bit 10 set, is acknowledged in that same cycle, and forgets every open row, so the next access issues ACTIVE without a PRECHARGE.
- R11: A write is acknowledged in the cycle of its WRITE command, and in that cycle `sd_dq_o` carries the write data with `sd_dq_oe_o` high.
- R12: During and after reset, until a request arrives: the command is NOP, `req_ack_o` is 0, `sd_dq_o` is 0, and no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_close_page_i | input | 1 | 1 = closed-page (auto-precharge), 0 = open-page |
| cfg_cas_i | input | 2 | CAS latency code |
| cfg_bus_release_i | input | 1 | 1 = release data bus except during writes |
| cfg_four_bank_i | input | 1 | 1 = four-bank devices, 0 = two-bank devices |
| req_valid_i | input | 1 | Request pending |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_pall_i | input | 1 | Request is a precharge-all |
| req_addr_i | input | ADDR_W | {bank, row, column} address |
| req_wdata_i | input | DATA_W | Write data |
| req_ack_o | output | 1 | One-cycle completion pulse |
| req_rdata_o | output | DATA_W | Read data, valid with ack |
| sd_cmd_o | output | 3 | {ras_n, cas_n, we_n} |
| sd_ba_o | output | 2 | Bank address |
| sd_addr_o | output | ROW_W | Row, or column with bit 10 = auto-precharge |
| sd_dq_o | output | DATA_W | Data driven to SDRAM |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dq_i | input | DATA_W | Data from SDRAM |

## Verification
The hardest case to reach is a bank conflict with the full PRECHARGE, ACTIVE, READ/WRITE chain. It also has to land while all four banks hold rows, so that a wrong bank index in the row table shows up as a false hit or a false miss. The stimulus table first opens a row in each bank and then revisits each of them. It forces one conflict and follows it with hits. After a precharge-all it reopens a row. Then it switches to closed-page mode while one bank still holds a row, so that the leftover row has to be closed before the access can proceed. The bench SDRAM model returns data only on the exact latency cycle, so a capture one cycle early or late reads a filler value.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_ACT,
    ST_WAIT_RW,
    ST_RD_WAIT
  } seq_state_e;

  // reserved code 00 falls back to the slowest latency
  function automatic logic [1:0] cas_cycles(input logic [1:0] code);
    return (code == 2'b00) ? 2'd3 : code;
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             ready_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // loaded with N at edge E, ready is seen at edge E+N
  assign ready_o = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ROW_W     = 12,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BA_W-1:0]  look_ba_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             clr_all_i,
  input  logic [BA_W-1:0]  upd_ba_i,
  input  logic [ROW_W-1:0] upd_row_i
);

  logic [NUM_BANKS-1:0] valid_w;
  logic [ROW_W-1:0]     rows_w [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             v_q;
    logic [ROW_W-1:0] r_q;
    logic             sel;

    assign sel = (upd_ba_i == BA_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        r_q <= '0;
      end else if (clr_all_i || (clr_i && sel)) begin
        v_q <= 1'b0;
      end else if (set_i && sel) begin
        v_q <= 1'b1;
        r_q <= upd_row_i;
      end
    end

    assign valid_w[b] = v_q;
    assign rows_w[b]  = r_q;
  end

  assign open_o = valid_w[look_ba_i];
  assign row_o  = rows_w[look_ba_i];

endmodule

// File: rtl/sdram_page_seq.sv
module sdram_page_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TRCD   = 2,
  parameter int unsigned TRP    = 2,
  localparam int unsigned BA_W   = 2,
  localparam int unsigned ADDR_W = BA_W + ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_close_page_i,
  input  logic [1:0]        cfg_cas_i,
  input  logic              cfg_bus_release_i,
  input  logic              cfg_four_bank_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_pall_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ack_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic [2:0]        sd_cmd_o,
  output logic [1:0]        sd_ba_o,
  output logic [ROW_W-1:0]  sd_addr_o,
  output logic [DATA_W-1:0] sd_dq_o,
  output logic              sd_dq_oe_o,
  input  logic [DATA_W-1:0] sd_dq_i
);

  localparam int unsigned NUM_BANKS = 1 << BA_W;
  localparam int unsigned AP_BIT    = 10;
  localparam int unsigned TMAX      = (TRCD > TRP) ? TRCD : TRP;
  localparam int unsigned TMAX3     = (TMAX > 3) ? TMAX : 3;
  localparam int unsigned TMR_W     = $clog2(TMAX3 + 1);

  // request decode
  logic [BA_W-1:0]  req_ba;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;

  assign req_ba  = cfg_four_bank_i ? req_addr_i[ADDR_W-1 -: BA_W]
                                   : {1'b0, req_addr_i[ADDR_W-2]};
  assign req_row = req_addr_i[COL_W +: ROW_W];
  assign req_col = req_addr_i[COL_W-1:0];

  // open-row table
  logic             bank_open;
  logic [ROW_W-1:0] bank_row;
  logic             tbl_set, tbl_clr, tbl_clr_all;

  sdram_bank_table #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
  ) u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .look_ba_i (req_ba),
    .open_o    (bank_open),
    .row_o     (bank_row),
    .set_i     (tbl_set),
    .clr_i     (tbl_clr),
    .clr_all_i (tbl_clr_all),
    .upd_ba_i  (req_ba),
    .upd_row_i (req_row)
  );

  logic row_hit, need_pre;
  assign row_hit  = bank_open && (bank_row == req_row) && !cfg_close_page_i;
  assign need_pre = bank_open && !row_hit;

  // delay timers: row-to-column, precharge recovery, CAS latency
  logic rcd_load, rp_load, cl_load;
  logic rcd_ready, rp_ready, cl_ready;

  sdram_gap_timer #(.CNT_W(TMR_W)) u_rcd (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (rcd_load),
    .val_i (TMR_W'(TRCD)), .ready_o (rcd_ready)
  );

  sdram_gap_timer #(.CNT_W(TMR_W)) u_rp (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (rp_load),
    .val_i (TMR_W'(TRP)), .ready_o (rp_ready)
  );

  sdram_gap_timer #(.CNT_W(TMR_W)) u_cl (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (cl_load),
    .val_i (TMR_W'(cas_cycles(cfg_cas_i))), .ready_o (cl_ready)
  );

  // sequencer
  seq_state_e       state_q, state_d;
  sd_cmd_e          cmd_q, cmd_d;
  logic [BA_W-1:0]  ba_q, ba_d;
  logic [ROW_W-1:0] addr_q, addr_d;
  logic             ack_q, ack_d;
  logic [DATA_W-1:0] rdata_q, dq_q;
  logic             wdata_load, rdata_load;
  logic             do_act, do_rw;

  always_comb begin
    state_d     = state_q;
    cmd_d       = CMD_NOP;
    ba_d        = ba_q;
    addr_d      = addr_q;
    ack_d       = 1'b0;
    tbl_set     = 1'b0;
    tbl_clr     = 1'b0;
    tbl_clr_all = 1'b0;
    rcd_load    = 1'b0;
    rp_load     = 1'b0;
    cl_load     = 1'b0;
    wdata_load  = 1'b0;
    rdata_load  = 1'b0;
    do_act      = 1'b0;
    do_rw       = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        // ack_q guard: master drops valid one cycle after ack
        if (req_valid_i && !ack_q) begin
          if (req_pall_i) begin
            cmd_d          = CMD_PRE;
            ba_d           = '0;
            addr_d         = '0;
            addr_d[AP_BIT] = 1'b1;
            tbl_clr_all    = 1'b1;
            rp_load        = 1'b1;
            ack_d          = 1'b1;
          end else if (need_pre) begin
            cmd_d   = CMD_PRE;
            ba_d    = req_ba;
            addr_d  = '0;
            tbl_clr = 1'b1;
            rp_load = 1'b1;
            state_d = ST_WAIT_ACT;
          end else if (row_hit) begin
            do_rw = 1'b1;
          end else if (rp_ready) begin
            do_act = 1'b1;
          end
        end
      end
      ST_WAIT_ACT: if (rp_ready)  do_act = 1'b1;
      ST_WAIT_RW:  if (rcd_ready) do_rw  = 1'b1;
      ST_RD_WAIT: begin
        if (cl_ready) begin
          rdata_load = 1'b1;
          ack_d      = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (do_act) begin
      cmd_d    = CMD_ACT;
      ba_d     = req_ba;
      addr_d   = req_row;
      tbl_set  = !cfg_close_page_i;
      rcd_load = 1'b1;
      state_d  = ST_WAIT_RW;
    end

    if (do_rw) begin
      ba_d           = req_ba;
      addr_d         = ROW_W'(req_col);
      addr_d[AP_BIT] = cfg_close_page_i;
      rp_load        = cfg_close_page_i;
      if (req_write_i) begin
        cmd_d      = CMD_WR;
        wdata_load = 1'b1;
        ack_d      = 1'b1;
        state_d    = ST_IDLE;
      end else begin
        cmd_d   = CMD_RD;
        cl_load = 1'b1;
        state_d = ST_RD_WAIT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      dq_q    <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      ack_q   <= ack_d;
      if (rdata_load) rdata_q <= sd_dq_i;
      if (wdata_load) dq_q    <= req_wdata_i;
    end
  end

  // data bus direction
  logic rd_busy;
  assign rd_busy = (state_q == ST_RD_WAIT) || (cmd_q == CMD_RD);

  assign sd_dq_oe_o  = (cmd_q == CMD_WR) || (!cfg_bus_release_i && !rd_busy);
  assign sd_dq_o     = dq_q;
  assign sd_cmd_o    = cmd_q;
  assign sd_ba_o     = ba_q;
  assign sd_addr_o   = addr_q;
  assign req_ack_o   = ack_q;
  assign req_rdata_o = rdata_q;

endmodule

// File: rtl/sdram_page_seq_chk.sv
module sdram_page_seq_chk #(
  parameter int unsigned TRCD = 2,
  parameter int unsigned TRP  = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_bus_release_i,
  input logic       cfg_four_bank_i,
  input logic       req_ack_o,
  input logic [2:0] sd_cmd_o,
  input logic       sd_ba_hi_i,
  input logic       sd_a10_i,
  input logic       sd_dq_oe_o
);
  import sdram_seq_pkg::*;

  logic is_act, is_rw, is_pre_evt;
  assign is_act     = (sd_cmd_o == CMD_ACT);
  assign is_rw      = (sd_cmd_o == CMD_RD) || (sd_cmd_o == CMD_WR);
  assign is_pre_evt = (sd_cmd_o == CMD_PRE) || (is_rw && sd_a10_i);

  // cycles elapsed since the last ACTIVE / precharge event, saturating
  logic [7:0] since_act, since_pre;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= 8'hFF;
      since_pre <= 8'hFF;
    end else begin
      if (is_act)                  since_act <= 8'd1;
      else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
      if (is_pre_evt)              since_pre <= 8'd1;
      else if (since_pre != 8'hFF) since_pre <= since_pre + 8'd1;
    end
  end

  a_r6_trcd_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rw |-> (since_act >= 8'(TRCD)));

  a_r6_trp_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> (since_pre >= 8'(TRP)));

  a_r8_release_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_bus_release_i && sd_dq_oe_o) |-> (sd_cmd_o == CMD_WR));

  a_r11_write_drives_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_cmd_o == CMD_WR) |-> sd_dq_oe_o);

  a_r9_two_bank_ba: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_four_bank_i && sd_cmd_o != CMD_NOP) |-> !sd_ba_hi_i);

  a_r10_pall_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_cmd_o == CMD_PRE && sd_a10_i) |-> req_ack_o);

  a_r12_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |=> !req_ack_o);

endmodule

bind sdram_page_seq sdram_page_seq_chk #(
  .TRCD (TRCD),
  .TRP  (TRP)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .cfg_bus_release_i (cfg_bus_release_i),
  .cfg_four_bank_i   (cfg_four_bank_i),
  .req_ack_o         (req_ack_o),
  .sd_cmd_o          (sd_cmd_o),
  .sd_ba_hi_i        (sd_ba_o[1]),
  .sd_a10_i          (sd_addr_o[10]),
  .sd_dq_oe_o        (sd_dq_oe_o)
);

// File: tb/tb_sdram_page_seq.sv
module tb_sdram_page_seq;
  import sdram_seq_pkg::*;

  localparam int ROW_W = 12, COL_W = 9, DATA_W = 16, TRCD = 2, TRP = 2;
  localparam int ADDR_W = 2 + ROW_W + COL_W;
  localparam logic [1:0] F_PRE = 2'd0, F_ACT = 2'd1, F_RW = 2'd2, F_PALL = 2'd3;

  function automatic logic [ADDR_W-1:0] mk(input int ba, input int row, input int col);
    return {ba[1:0], row[ROW_W-1:0], col[COL_W-1:0]};
  endfunction

  typedef struct packed {
    logic [3:0]        rq;
    logic              close;
    logic [1:0]        cas;
    logic              pall;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        first;
  } vec_t;

  // R1 closed page, R2 idle-bank miss, R3 hit, R4 conflict, R5 four banks,
  // R7 reserved CAS, R10 precharge-all
  localparam vec_t VEC [16] = '{
    '{4'd1,  1'b1, 2'd2, 1'b0, 1'b0, mk(0,5,3),  F_ACT},
    '{4'd1,  1'b1, 2'd2, 1'b0, 1'b1, mk(0,5,4),  F_ACT},
    '{4'd2,  1'b0, 2'd3, 1'b0, 1'b0, mk(1,7,1),  F_ACT},
    '{4'd3,  1'b0, 2'd3, 1'b0, 1'b0, mk(1,7,2),  F_RW},
    '{4'd4,  1'b0, 2'd3, 1'b0, 1'b1, mk(1,9,0),  F_PRE},
    '{4'd3,  1'b0, 2'd1, 1'b0, 1'b0, mk(1,9,5),  F_RW},
    '{4'd5,  1'b0, 2'd2, 1'b0, 1'b1, mk(2,1,6),  F_ACT},
    '{4'd5,  1'b0, 2'd2, 1'b0, 1'b1, mk(3,2,7),  F_ACT},
    '{4'd5,  1'b0, 2'd2, 1'b0, 1'b1, mk(0,3,8),  F_ACT},
    '{4'd7,  1'b0, 2'd0, 1'b0, 1'b0, mk(2,1,9),  F_RW},
    '{4'd5,  1'b0, 2'd2, 1'b0, 1'b0, mk(3,2,10), F_RW},
    '{4'd5,  1'b0, 2'd2, 1'b0, 1'b1, mk(0,3,11), F_RW},
    '{4'd10, 1'b0, 2'd2, 1'b1, 1'b0, '0,         F_PALL},
    '{4'd10, 1'b0, 2'd2, 1'b0, 1'b0, mk(1,9,12), F_ACT},
    '{4'd1,  1'b1, 2'd3, 1'b0, 1'b0, mk(1,9,13), F_PRE},
    '{4'd1,  1'b1, 2'd3, 1'b0, 1'b1, mk(1,9,14), F_ACT}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              cfg_close = 1'b0, cfg_rel = 1'b0, cfg_four = 1'b1;
  logic [1:0]        cfg_cas = 2'd2;
  logic              req_valid = 1'b0, req_write = 1'b0, req_pall = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ack, sd_oe;
  logic [DATA_W-1:0] req_rdata, sd_dq_o;
  logic [DATA_W-1:0] sd_dq_i = '0;
  logic [2:0]        sd_cmd;
  logic [1:0]        sd_ba;
  logic [ROW_W-1:0]  sd_addr;

  sdram_page_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .TRCD(TRCD), .TRP(TRP)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_close_page_i(cfg_close), .cfg_cas_i(cfg_cas),
    .cfg_bus_release_i(cfg_rel), .cfg_four_bank_i(cfg_four),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_pall_i(req_pall),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ack_o(req_ack), .req_rdata_o(req_rdata),
    .sd_cmd_o(sd_cmd), .sd_ba_o(sd_ba), .sd_addr_o(sd_addr),
    .sd_dq_o(sd_dq_o), .sd_dq_oe_o(sd_oe), .sd_dq_i(sd_dq_i)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_cl(input logic [1:0] c);
    return (c == 2'b00) ? 3 : int'(c);
  endfunction

  function automatic logic [DATA_W-1:0] model_data(input logic [1:0] ba, input logic [8:0] col);
    return {ba, 5'h15, col};
  endfunction

  function automatic logic [1:0] exp_ba(input logic [ADDR_W-1:0] a);
    return cfg_four ? a[ADDR_W-1 -: 2] : {1'b0, a[ADDR_W-2]};
  endfunction

  // SDRAM read model: data valid only in the CL-th cycle after READ
  int unsigned       rd_cnt = 0;
  logic [DATA_W-1:0] rd_val = '0;
  always @(negedge clk) begin
    if (sd_cmd == CMD_RD) begin
      rd_cnt = exp_cl(cfg_cas);
      rd_val = model_data(sd_ba, sd_addr[8:0]);
    end
    if (rd_cnt == 1) sd_dq_i <= rd_val;
    else             sd_dq_i <= 16'hDEAD;
    if (rd_cnt != 0) rd_cnt--;
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // trace of one request
  int   t_pre, t_act, t_rw, t_ack, first, oe_bad;
  logic rw_a10, rw_oe;
  logic [1:0]        rw_ba;
  logic [DATA_W-1:0] rw_dq, got_rdata;

  task automatic run_req(input logic pall, input logic wr,
                         input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd);
    req_pall = pall; req_write = wr; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    t_pre = -1; t_act = -1; t_rw = -1; t_ack = -1; first = -1; oe_bad = 0;
    for (int t = 1; t <= 60; t++) begin
      @(negedge clk);
      case (sd_cmd)
        CMD_PRE: begin t_pre = t; if (first < 0) first = sd_addr[10] ? F_PALL : F_PRE; end
        CMD_ACT: begin t_act = t; if (first < 0) first = F_ACT; end
        CMD_RD, CMD_WR: begin
          t_rw = t; rw_a10 = sd_addr[10]; rw_oe = sd_oe; rw_dq = sd_dq_o; rw_ba = sd_ba;
          if (first < 0) first = F_RW;
        end
        default: ;
      endcase
      if (cfg_rel && sd_oe && sd_cmd != CMD_WR) oe_bad++;
      if (req_ack) begin t_ack = t; got_rdata = req_rdata; break; end
    end
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_access(input string tag, input logic wr, input logic close,
                              input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] wd);
    chk({tag, " ack seen"}, 32'(t_ack > 0), 32'd1);
    if (t_pre > 0 && t_act > 0) chk("R6 PRE->ACT gap", 32'(t_act - t_pre), 32'(TRP));
    if (t_act > 0) chk("R6 ACT->RW gap", 32'(t_rw - t_act), 32'(TRCD));
    chk({tag, " auto-precharge bit"}, 32'(rw_a10), 32'(close));
    chk({tag, " bank"}, 32'(rw_ba), 32'(exp_ba(addr)));
    if (wr) begin
      chk("R11 ack with WRITE", 32'(t_ack), 32'(t_rw));
      chk("R11 write data", 32'(rw_dq), 32'(wd));
      chk("R11 write oe", 32'(rw_oe), 32'd1);
    end else begin
      chk("R7 CAS latency", 32'(t_ack - t_rw), 32'(exp_cl(cfg_cas)));
      chk("R7 read data", 32'(got_rdata), 32'(model_data(exp_ba(addr), addr[8:0])));
    end
  endtask

  logic [DATA_W-1:0] last_wd = '0;

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12 cmd NOP in reset", 32'(sd_cmd), 32'(3'b111));
    chk("R12 ack low in reset", 32'(req_ack), 32'd0);
    chk("R12 dq zero in reset", 32'(sd_dq_o), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 cmd NOP after reset", 32'(sd_cmd), 32'(3'b111));
    chk("R8 idle oe driven", 32'(sd_oe), 32'd1);

    for (int i = 0; i < 16; i++) begin
      string tag;
      logic [DATA_W-1:0] wd;
      tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
      wd = 16'h1000 + 16'(i);
      cfg_close = VEC[i].close;
      cfg_cas   = VEC[i].cas;
      run_req(VEC[i].pall, VEC[i].wr, VEC[i].addr, wd);
      chk({tag, " first command"}, 32'(first), 32'(VEC[i].first));
      if (VEC[i].first == F_RW || VEC[i].first == F_ACT || VEC[i].first == F_PALL)
        chk({tag, " first at t=1"},
            32'((VEC[i].first == F_ACT) ? t_act : (VEC[i].first == F_RW) ? t_rw : t_pre), 32'd1);
      if (VEC[i].pall) begin
        chk("R10 ack with precharge-all", 32'(t_ack), 32'(t_pre));
      end else begin
        check_access(tag, VEC[i].wr, VEC[i].close, VEC[i].addr, wd);
        if (VEC[i].wr) last_wd = wd;
      end
    end

    // R8 idle bus behaviour
    cfg_close = 1'b0; cfg_cas = 2'd2;
    @(negedge clk);
    chk("R8 idle oe with release=0", 32'(sd_oe), 32'd1);
    chk("R8 idle dq holds last write", 32'(sd_dq_o), 32'(last_wd));
    cfg_rel = 1'b1;
    @(negedge clk);
    chk("R8 idle oe with release=1", 32'(sd_oe), 32'd0);
    run_req(1'b0, 1'b1, mk(2,6,7), 16'hBEEF);
    chk("R8 oe only on WRITE", 32'(oe_bad), 32'd0);
    check_access("R8 write", 1'b1, 1'b0, mk(2,6,7), 16'hBEEF);
    run_req(1'b0, 1'b0, mk(2,6,8), 16'h0);
    chk("R8 oe off during read", 32'(oe_bad), 32'd0);
    chk("R3 hit under release", 32'(first), 32'(F_RW));
    cfg_rel = 1'b0;

    // R9 two-bank devices
    run_req(1'b1, 1'b0, '0, '0);
    chk("R10 clear before R9", 32'(first), 32'(F_PALL));
    cfg_four = 1'b0;
    run_req(1'b0, 1'b0, mk(3,4,1), '0);
    chk("R9 miss opens bank", 32'(first), 32'(F_ACT));
    chk("R9 bank high bit dropped", 32'(rw_ba), 32'd1);
    run_req(1'b0, 1'b0, mk(1,4,2), '0);
    chk("R9 alias is a hit", 32'(first), 32'(F_RW));
    check_access("R9 alias read", 1'b0, 1'b0, mk(1,4,2), '0);
    cfg_four = 1'b1;
    run_req(1'b0, 1'b0, mk(3,4,3), '0);
    chk("R5 bank3 separate from bank1", 32'(first), 32'(F_ACT));
    chk("R5 bank3 used", 32'(rw_ba), 32'd3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule